// File: doc/BRIEF.md
# TDM Receive Slot Deserializer

This block takes the serial data line of a time-division-multiplexed audio link and turns it into parallel words. It watches the bit clock, samples data and frame sync on the edge chosen by a polarity input, and builds each slot of the frame bit by bit with the most significant bit first. At the end of every slot whose index is inside the programmed slot count, it extracts a word of the programmed length. The word is taken from either the start or the end of the slot. The word is stored, zero-extended, in a 32-entry first-word-fall-through FIFO.

The reader drains the FIFO through a simple pop strobe. A service request is raised while the fill level is at or above a threshold, either half or a quarter of the depth. A word that finds the FIFO full is lost, and a sticky flag records the loss. Bit-clock and frame-sync generation are outside the block. The bit clock arrives already synchronous to `clk_i` and held for at least one `clk_i` cycle per level.

Control field layout in `cfg_i`: bit 0 enable, bit 1 justify, bits 3:2 slot length code, bits 7:4 slot count, bits 10:8 word length code, bit 11 threshold select.

Top module: `tdm_rx_deser`

## Requirements
- R1: With `clk_pol_i`=0 the line is sampled on falling `bclk_i` edges, and with `clk_pol_i`=1 on rising edges. Levels seen at the other edge have no effect.
- R2: `fs_i` high at a capture edge marks bit 0 (the MSB) of slot 0. Later slots follow back to back, MSB first, each the programmed slot length.
- R3: Slot length code (bits 3:2) 0, 1 and 2 select 8, 16 and 32 bits per slot. Code 3 acts as 32.
- R4: Word length code (bits 10:8) 0, 1, 2, 3 and 4 select 8, 16, 20, 24 and 32 bits. Codes 5 to 7 act as 32, and a word longer than the slot is cut to the slot length. Each word is stored zero-extended with its LSB at bit 0.
- R5: Justify bit 1 = 1 takes the word from the first received bits of the slot. Justify = 0 takes it from the last received bits.
- R6: Only slots with index below the slot count (bits 7:4) produce a word. Count 0 captures nothing, and slots at or past the count are ignored until the next frame sync.
- R7: While enable (bit 0) is 0, no word is captured and frame state is dropped. After enable is set, capture starts at the next frame sync, with the other fields taking effect as given.
- R8: The FIFO holds 32 words, presents the oldest word on `rd_data_o` while `empty_o` is 0, and removes it when `rd_i` is high at a clock edge. `fill_o` gives the word count, and a pop when empty has no effect.
- R9: `dreq_o` is high when `fill_o` is at least 16 with bit 11 = 0, or at least 8 with bit 11 = 1.
- R10: A word completed while the FIFO is full and not being read in that cycle is dropped. `ovf_o` then goes high and stays high until reset.
- R11: After reset the FIFO is empty, `fill_o` is 0, and `dreq_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 12 | Receive control word |
| clk_pol_i | input | 1 | Capture edge select: 0 falling, 1 rising |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fs_i | input | 1 | Frame sync, marks bit 0 of slot 0 |
| sd_i | input | 1 | Serial data |
| rd_i | input | 1 | FIFO pop strobe |
| rd_data_o | output | 32 | Oldest FIFO word |
| empty_o | output | 1 | FIFO empty |
| fill_o | output | 6 | FIFO word count |
| dreq_o | output | 1 | Service request |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A wrong bit or slot counter does not stay hidden. It shifts or swaps data at the next slot boundary, and the shifted data shows up as a wrong word at the FIFO head on the following read. It can also change the number of words a frame leaves behind, and `fill_o` shows that as soon as the frame ends. A wrong FIFO pointer or count shows up in the next pop, through the order of words or `empty_o`, or in `dreq_o` at the threshold crossing. A lost overflow condition shows in `ovf_o` one cycle after the dropped word.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned CFG_W    = 12;
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_JUST   = 1;
  localparam int unsigned B_SL_LO  = 2;
  localparam int unsigned B_CNT_LO = 4;
  localparam int unsigned B_WL_LO  = 8;
  localparam int unsigned B_THR    = 11;

  typedef struct packed {
    logic       thr_quarter;
    logic [2:0] wl_code;
    logic [3:0] slot_cnt;
    logic [1:0] sl_code;
    logic       left_just;
    logic       en;
  } rx_cfg_t;

  function automatic logic [6:0] slot_len(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd8;
      2'd1:    return 7'd16;
      default: return 7'd32;
    endcase
  endfunction

  function automatic logic [6:0] word_len(input logic [2:0] code);
    case (code)
      3'd0:    return 7'd8;
      3'd1:    return 7'd16;
      3'd2:    return 7'd20;
      3'd3:    return 7'd24;
      default: return 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic pol_i,
  output logic cap_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  // pol 0: falling edge, pol 1: rising edge
  assign cap_o = pol_i ? (bclk_i & ~bclk_q) : (~bclk_i & bclk_q);
endmodule

// File: rtl/tdm_rx_slot.sv
module tdm_rx_slot
  import tdm_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              sd_i,
  input  logic              fs_i,
  input  rx_cfg_t           cfg_i,
  output logic              push_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned BW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, full_v, slot_v, sl_mask, w_mask;
  logic [BW-1:0]     bit_q;
  logic [3:0]        slot_q;
  logic              in_frame_q;
  logic [6:0]        sl_bits, wl_raw, wl_eff;
  logic              slot_end;

  always_comb begin
    sl_bits = slot_len(cfg_i.sl_code);
    wl_raw  = word_len(cfg_i.wl_code);
    wl_eff  = (wl_raw > sl_bits) ? sl_bits : wl_raw;
    full_v  = {sh_q[DATA_W-2:0], sd_i};
    for (int i = 0; i < DATA_W; i++) begin
      sl_mask[i] = (7'(i) < sl_bits);
      w_mask[i]  = (7'(i) < wl_eff);
    end
    slot_v = full_v & sl_mask;
    if (cfg_i.left_just) word_o = (slot_v >> (sl_bits - wl_eff)) & w_mask;
    else                 word_o = slot_v & w_mask;
    slot_end = ({2'b0, bit_q} == (sl_bits - 7'd1));
  end

  assign push_o = cap_i & cfg_i.en & in_frame_q & ~fs_i & slot_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_q      <= '0;
      slot_q     <= '0;
      in_frame_q <= 1'b0;
    end else if (cap_i) begin
      if (!cfg_i.en) begin
        in_frame_q <= 1'b0;
      end else if (fs_i) begin
        in_frame_q <= (cfg_i.slot_cnt != 4'd0);
        bit_q      <= BW'(1);
        slot_q     <= '0;
        sh_q       <= DATA_W'(sd_i);
      end else if (in_frame_q) begin
        sh_q <= full_v;
        if (slot_end) begin
          bit_q  <= '0;
          slot_q <= slot_q + 4'd1;
          if ({1'b0, slot_q} + 5'd1 >= {1'b0, cfg_i.slot_cnt}) in_frame_q <= 1'b0;
        end else begin
          bit_q <= bit_q + BW'(1);
        end
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (slot_q < cfg_i.slot_cnt)); // R6
  AST_PUSH_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o); // R1
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     pop_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [$clog2(DEPTH):0]   fill_o,
  output logic                     empty_o,
  output logic                     ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              full, do_pop, do_push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full | do_pop);
  assign rdata_o = mem_q[rd_q];
  assign fill_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push_i & ~do_push) ovf_o <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R10
  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (ovf_o && cnt_q == CW'(DEPTH))); // R10
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o); // R8
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CFG_W-1:0]       cfg_i,
  input  logic                   clk_pol_i,
  input  logic                   bclk_i,
  input  logic                   fs_i,
  input  logic                   sd_i,
  input  logic                   rd_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   empty_o,
  output logic [$clog2(DEPTH):0] fill_o,
  output logic                   dreq_o,
  output logic                   ovf_o
);
  localparam int unsigned CW      = $clog2(DEPTH) + 1;
  localparam int unsigned THR_HLF = DEPTH / 2;
  localparam int unsigned THR_QTR = DEPTH / 4;

  rx_cfg_t           cfg;
  logic              cap, push;
  logic [DATA_W-1:0] word;

  assign cfg = rx_cfg_t'(cfg_i);

  tdm_rx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bclk_i(bclk_i),
    .pol_i (clk_pol_i),
    .cap_o (cap)
  );

  tdm_rx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .sd_i  (sd_i),
    .fs_i  (fs_i),
    .cfg_i (cfg),
    .push_o(push),
    .word_o(word)
  );

  tdm_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(word),
    .pop_i  (rd_i),
    .rdata_o(rd_data_o),
    .fill_o (fill_o),
    .empty_o(empty_o),
    .ovf_o  (ovf_o)
  );

  assign dreq_o = fill_o >= (cfg.thr_quarter ? CW'(THR_QTR) : CW'(THR_HLF));

  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !rd_i && fill_o < CW'(DEPTH)) |=> (fill_o == $past(fill_o) + CW'(1))); // R8
  AST_DISABLED_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.en && !rd_i) |=> (fill_o <= $past(fill_o))); // R7
endmodule

// File: tb/tdm_rx_deser_bench.sv
module tdm_rx_deser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg = '0;
  logic        pol = 1'b0, bclk = 1'b1, fs = 1'b0, sd = 1'b0, rd = 1'b0;
  logic [31:0] rd_data;
  logic        empty, dreq, ovf;
  logic [5:0]  fill;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned exp_q[$];

  always #5 clk = ~clk;

  tdm_rx_deser u_tdm_rx_deser (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .clk_pol_i(pol), .bclk_i(bclk),
    .fs_i(fs), .sd_i(sd), .rd_i(rd), .rd_data_o(rd_data), .empty_o(empty),
    .fill_o(fill), .dreq_o(dreq), .ovf_o(ovf)
  );

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sl_of(int c); return c == 0 ? 8 : c == 1 ? 16 : 32; endfunction
  function automatic int wl_of(int c);
    case (c) 0: return 8; 1: return 16; 2: return 20; 3: return 24; default: return 32; endcase
  endfunction
  function automatic int unsigned exp_word(int unsigned v, int sb, int wb, bit lj);
    int w = (wb > sb) ? sb : wb;
    longint unsigned m = (64'd1 << w) - 1;
    return lj ? int'((longint'(v) >> (sb - w)) & m) : int'(longint'(v) & m);
  endfunction
  function automatic logic [11:0] mk_cfg(bit thr, int wl, int cnt, int sl, bit lj, bit en);
    return {thr, 3'(wl), 4'(cnt), 2'(sl), lj, en};
  endfunction

  task automatic set_pol(bit p);
    @(negedge clk); pol = p; bclk = p ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // capture edge first, then opposite-level data at the non-capture edge
  task automatic send_bit(bit b, bit f);
    sd = b; fs = f; @(negedge clk);
    bclk = ~bclk; @(negedge clk);
    sd = ~b; fs = 1'b0; @(negedge clk);
    bclk = ~bclk; @(negedge clk);
  endtask

  task automatic send_slot(int unsigned v, int sb, bit first);
    for (int i = sb - 1; i >= 0; i--) send_bit(v[i], first && (i == sb - 1));
  endtask

  // sends nsl slots of random data, models the words the block should keep
  task automatic send_frame(int nsl, bit model);
    int sb = sl_of(int'(cfg[3:2]));
    for (int s = 0; s < nsl; s++) begin
      int unsigned v = $urandom;
      if (sb < 32) v = v & ((32'd1 << sb) - 1);
      send_slot(v, sb, s == 0);
      if (model && cfg[0] && s < int'(cfg[7:4]) && exp_q.size() < 32)
        exp_q.push_back(exp_word(v, sb, wl_of(int'(cfg[10:8])), cfg[1]));
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      int unsigned e = exp_q.pop_front();
      chk({req, " not empty"}, empty, 0);
      chk({req, " data"}, rd_data, e);
      rd = 1'b1; @(negedge clk); rd = 1'b0;
    end
    chk({req, " empty after drain"}, empty, 1);
  endtask

  initial begin
    int unsigned dv;
    void'($urandom(32'h1c3d5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 empty", empty, 1); chk("R11 fill", fill, 0);
    chk("R11 dreq", dreq, 0);   chk("R11 ovf", ovf, 0);

    // R8 pop on empty is harmless
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R8 pop empty", fill, 0);

    // R5 R4 directed: 32-bit slot, 20-bit word
    set_pol(0);
    cfg = mk_cfg(0, 2, 1, 2, 1, 1);
    dv = 32'hABCDE123;
    send_slot(dv, 32, 1); repeat (2) @(negedge clk);
    chk("R5 left justify", rd_data, 32'h000ABCDE);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    cfg = mk_cfg(0, 2, 1, 2, 0, 1);
    send_slot(dv, 32, 1); repeat (2) @(negedge clk);
    chk("R5 right justify", rd_data, 32'h000DE123);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    // R4 word longer than slot is cut
    cfg = mk_cfg(0, 4, 1, 0, 1, 1);
    send_slot(32'h5A, 8, 1); repeat (2) @(negedge clk);
    chk("R4 clamp to slot", rd_data, 32'h5A);
    rd = 1'b1; @(negedge clk); rd = 1'b0;

    // R1 R2 R3 R4 R5 R6 random frames
    for (int it = 0; it < 30; it++) begin
      int cnt = $urandom_range(0, 8);
      set_pol(1'($urandom_range(0, 1)));
      cfg = mk_cfg(0, $urandom_range(0, 7), cnt, $urandom_range(0, 3),
                   1'($urandom_range(0, 1)), 1);
      send_frame(cnt + 2, 1);
      chk("R6 words per frame", fill, exp_q.size());
      drain("R1 R2 R3 R4 R5 random frame");
    end

    // R7 disabled: nothing captured
    set_pol(0);
    cfg = mk_cfg(0, 1, 4, 1, 0, 0);
    send_frame(4, 0);
    chk("R7 disabled frame", fill, 0);
    // enable set mid-frame: waits for next sync
    send_slot(32'h1234, 16, 1);
    cfg[0] = 1'b1;
    for (int s = 0; s < 3; s++) send_slot(32'h4321, 16, 0);
    repeat (2) @(negedge clk);
    chk("R7 enable mid-frame", fill, 0);
    send_frame(4, 1);
    chk("R7 resumed fill", fill, 4);
    drain("R7 resumed");

    // R9 thresholds
    cfg = mk_cfg(0, 0, 7, 0, 0, 1);
    send_frame(7, 1);
    chk("R9 fill7 half", dreq, 0);
    cfg[11] = 1'b1; @(negedge clk);
    chk("R9 fill7 quarter", dreq, 0);
    cfg[7:4] = 4'd1; send_frame(1, 1);
    chk("R9 fill8 quarter", dreq, 1);
    cfg[11] = 1'b0; @(negedge clk);
    chk("R9 fill8 half", dreq, 0);
    cfg[7:4] = 4'd7; send_frame(7, 1);
    chk("R9 fill15 half", dreq, 0);
    cfg[7:4] = 4'd1; send_frame(1, 1);
    chk("R9 fill16 half", dreq, 1);
    drain("R9 data");

    // R10 overflow
    cfg = mk_cfg(0, 0, 8, 0, 1, 1);
    for (int f = 0; f < 4; f++) send_frame(8, 1);
    chk("R10 full fill", fill, 32);
    chk("R10 no ovf yet", ovf, 0);
    cfg[7:4] = 4'd3; send_frame(3, 1);
    chk("R10 fill held", fill, 32);
    chk("R10 ovf set", ovf, 1);
    drain("R10 kept words");
    chk("R10 ovf sticky", ovf, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule